// File: doc/BRIEF.md
# Packed byte shuffle unit

This block rearranges the bytes of a data vector under the control of a second vector holding one control byte per output lane. Each control byte either forces its output lane to zero or names the data byte that the lane takes. Two widths are supported. The wide mode works on 16 byte lanes and uses a 4-bit lane index. The narrow mode works on the lower 8 lanes and uses a 3-bit lane index. The control vector is never written. Only the permuted data appears at the output.

The result is registered, so it appears one clock after the input strobe. When the control vector comes from memory in wide mode, the block checks that its address is 16-byte aligned. A misaligned address raises a fault flag in place of a result.

Top module: `byte_permute_unit`

## Requirements
- R1: When bit 7 of control byte i is 1, output byte i is zero.
- R2: In wide mode (`narrow_mode`=0), when control bit 7 is 0, output byte i equals data byte number ctrl[3:0] (byte k is data bits 8k+7..8k).
- R3: In narrow mode (`narrow_mode`=1), output byte i (i<8) equals data byte number ctrl[2:0], taken from the lower 64 data bits only. Data bits 127..64 have no effect.
- R4: Control bits 6..4 in wide mode, and bits 6..3 in narrow mode, have no effect on the output.
- R5: Every lane reads the original input vector, so several lanes may select the same source byte.
- R6: In narrow mode, output bits 127..64 are zero.
- R7: `out_valid` equals `in_valid` delayed by exactly one clock.
- R8: In wide mode, an accepted input with `mask_from_mem`=1 and `mask_addr`[3:0] not equal to 0 sets `align_fault` with `out_valid`, and the output data is zero. Narrow mode and register-sourced masks never fault.
- R9: A synchronous active-high reset clears `out_data`, `out_valid` and `align_fault`.
- R10: Without `in_valid`, the output data and the fault flag hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| narrow_mode | input | 1 | 1 selects 8-lane mode, 0 selects 16-lane mode |
| data_vec | input | 128 | Vector to permute |
| ctrl_vec | input | 128 | Per-lane control bytes |
| mask_from_mem | input | 1 | Control vector was read from memory |
| mask_addr | input | 64 | Address of the memory control vector |
| out_data | output | 128 | Permuted result |
| out_valid | output | 1 | Result strobe |
| align_fault | output | 1 | Misaligned memory mask in wide mode |

## Verification
The bench targets these failure modes:
- Control bytes whose bits 6..4 or 6..3 are set. A design that decodes a wider index would pull the wrong byte or, in narrow mode, reach the upper half.
- Narrow-mode patterns with non-zero upper data. These expose a design that leaks upper bytes or leaves the top half of the output non-zero.
- Masks where several lanes name one source byte, and a reversal pattern. These catch any lane reading an already-updated value.
- Misaligned and aligned memory addresses in both modes, and idle cycles between transfers. These expose a fault that is raised in the wrong mode, data that is not zeroed on a fault, or output registers that do not hold while idle.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int unsigned LANES_WIDE   = 16;
  localparam int unsigned LANES_NARROW = 8;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned VEC_W        = LANES_WIDE * BYTE_W;
  localparam int unsigned IDX_W        = $clog2(LANES_WIDE);
  localparam int unsigned ALIGN_BITS   = $clog2(LANES_WIDE);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [VEC_W-1:0]  vec_t;

  // Lane index taken from one control byte, width set by the mode.
  function automatic logic [IDX_W-1:0] lane_index(input byte_t c, input logic narrow);
    logic [IDX_W-1:0] idx;
    idx = c[IDX_W-1:0];
    if (narrow) idx[IDX_W-1] = 1'b0;
    return idx;
  endfunction

  // Alignment test for a memory-sourced control vector.
  function automatic logic misaligned(input logic [63:0] addr);
    return |addr[ALIGN_BITS-1:0];
  endfunction
endpackage

// File: rtl/bpu_lane_select.sv
module bpu_lane_select
  import bpu_pkg::*;
#(
  parameter int unsigned LANE = 0
) (
  input  vec_t  src,
  input  byte_t ctrl,
  input  logic  narrow,
  output byte_t res
);
  localparam bit UPPER = (LANE >= LANES_NARROW);
  logic [IDX_W-1:0] idx;
  logic             zero_lane;

  always_comb begin
    idx       = lane_index(ctrl, narrow);
    zero_lane = ctrl[BYTE_W-1] || (narrow && UPPER);
    res       = zero_lane ? '0 : src[idx*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bpu_fault_check.sv
module bpu_fault_check
  import bpu_pkg::*;
(
  input  logic        from_mem,
  input  logic        narrow,
  input  logic [63:0] addr,
  output logic        fault
);
  always_comb fault = from_mem && !narrow && misaligned(addr);
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bpu_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         narrow_mode,
  input  logic [127:0] data_vec,
  input  logic [127:0] ctrl_vec,
  input  logic         mask_from_mem,
  input  logic [63:0]  mask_addr,
  output logic [127:0] out_data,
  output logic         out_valid,
  output logic         align_fault
);
  vec_t perm_vec;
  logic fault_now;
  logic load_result;

  for (genvar g = 0; g < LANES_WIDE; g++) begin : g_lane
    bpu_lane_select #(.LANE(g)) u_sel (
      .src   (data_vec),
      .ctrl  (ctrl_vec[g*BYTE_W +: BYTE_W]),
      .narrow(narrow_mode),
      .res   (perm_vec[g*BYTE_W +: BYTE_W])
    );
  end

  bpu_fault_check u_fault (
    .from_mem(mask_from_mem),
    .narrow  (narrow_mode),
    .addr    (mask_addr),
    .fault   (fault_now)
  );

  assign load_result = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data    <= '0;
      out_valid   <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (load_result) begin
        out_data    <= fault_now ? '0 : perm_vec;
        align_fault <= fault_now;
      end
    end
  end
endmodule

// File: rtl/byte_permute_unit_chk.sv
module byte_permute_unit_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         narrow_mode,
  input logic         mask_from_mem,
  input logic [63:0]  mask_addr,
  input logic [127:0] out_data,
  input logic         out_valid,
  input logic         align_fault
);
  // R7
  a_r7_valid_delay: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R8
  a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> out_data == '0);
  a_r8_fault_raised: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_from_mem && !narrow_mode && mask_addr[3:0] != 4'd0) |=> (align_fault && out_valid));
  a_r8_narrow_nofault: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_mode) |=> !align_fault);
  // R6
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow_mode) |=> out_data[127:64] == '0);
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> ($stable(out_data) && $stable(align_fault)));
endmodule

bind byte_permute_unit byte_permute_unit_chk u_chk (.*);

// File: tb/byte_permute_unit_test.sv
module byte_permute_unit_test;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic         narrow_mode;
  logic [127:0] data_vec;
  logic [127:0] ctrl_vec;
  logic         mask_from_mem;
  logic [63:0]  mask_addr;
  logic [127:0] out_data;
  logic         out_valid;
  logic         align_fault;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [127:0] data;
    logic         fault;
    string        tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  byte_permute_unit uut (.*);

  function automatic exp_t model(input logic [127:0] d, input logic [127:0] c,
                                 input logic nm, input logic mem,
                                 input logic [63:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    e.fault = mem && !nm && (a % 16 != 0);
    e.data = '0;
    if (!e.fault) begin
      for (int i = 0; i < (nm ? 8 : 16); i++) begin
        int sel;
        sel = nm ? (c[i*8 +: 8] % 8) : (c[i*8 +: 8] % 16);
        if (!c[i*8+7]) e.data[i*8 +: 8] = d[sel*8 +: 8];
      end
    end
    return e;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] d, input logic [127:0] c, input logic nm,
                      input logic mem, input logic [63:0] a, input string tag);
    @(negedge clk);
    in_valid = 1; data_vec = d; ctrl_vec = c; narrow_mode = nm;
    mask_from_mem = mem; mask_addr = a;
    q.push_back(model(d, c, nm, mem, a, tag));
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor: in the cycle after an input is accepted, the result is registered.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R7 unexpected out_valid", {127'd0, out_valid}, 128'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_data == e.data, e.tag, out_data, e.data);
        chk(align_fault == e.fault, {e.tag, " R8 fault"}, {127'd0, align_fault}, {127'd0, e.fault});
      end
    end
  end

  logic [127:0] seq_data;
  logic [127:0] ctl;

  initial begin
    rst = 1; in_valid = 0; narrow_mode = 0; data_vec = '0; ctrl_vec = '0;
    mask_from_mem = 0; mask_addr = '0;
    for (int i = 0; i < 16; i++) seq_data[i*8 +: 8] = 8'hA0 + 8'(i);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_data == '0 && !out_valid && !align_fault, "R9 reset", out_data, '0);
    rst = 0;

    // R2 identity and reversal
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'(i);
    send(seq_data, ctl, 0, 0, 0, "R2 identity");
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'(15 - i);
    send(seq_data, ctl, 0, 0, 0, "R2 R5 reverse");
    // R1 zeroing lanes
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = (i % 2 == 1) ? 8'h80 + 8'(i) : 8'(i);
    send(seq_data, ctl, 0, 0, 0, "R1 zero lanes");
    // R5 broadcast
    send(seq_data, {16{8'h07}}, 0, 0, 0, "R5 broadcast");
    // R4 ignored bits wide
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'h70 | 8'(i ^ 5);
    send(seq_data, ctl, 0, 0, 0, "R4 wide ignored bits");
    // R3 R6 narrow with ignored bits and upper indices
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'h78 | 8'(7 - (i % 8));
    send(seq_data, ctl, 1, 0, 0, "R3 R4 R6 narrow");
    for (int i = 0; i < 16; i++) ctl[i*8 +: 8] = 8'(8 + (i % 8));
    send(seq_data, ctl, 1, 0, 0, "R3 narrow upper idx");
    // R8 faults
    send(seq_data, {16{8'h03}}, 0, 1, 64'h1008, "R8 misaligned wide");
    send(seq_data, {16{8'h03}}, 0, 1, 64'h1000, "R8 aligned wide");
    send(seq_data, {16{8'h03}}, 1, 1, 64'h1004, "R8 narrow no fault");
    send(seq_data, {16{8'h03}}, 0, 0, 64'h1001, "R8 register mask");
    send(seq_data, {16{8'h02}}, 0, 1, 64'h000F, "R8 misaligned low");
    // R10 hold during idle
    send(seq_data, {16{8'h0C}}, 0, 0, 0, "R10 last");
    repeat (3) @(negedge clk);
    begin
      exp_t e;
      e = model(seq_data, {16{8'h0C}}, 0, 0, 0, "R10");
      chk(out_data == e.data && !out_valid, "R10 hold idle", out_data, e.data);
    end
    // R7 idle produced nothing
    chk(q.size() == 0, "R7 queue drained", 128'(q.size()), 128'd0);
    // R9 reset after activity
    rst = 1;
    @(negedge clk);
    chk(out_data == '0 && !out_valid && !align_fault, "R9 reset again", out_data, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule